// File: doc/BRIEF.md
# Coherence Line-State Controller

This block keeps the coherence state of every line in one core's private write-back cache. Each line is in one of four states: Modified, Exclusive, Shared or Invalid. The block takes local requests from its own core: read, write, and clean, where clean writes a dirty line back. It also takes snooped events from other cores on the shared bus: remote read and remote invalidate. For each event it works out the line's next state. When the protocol needs bus traffic, it runs one of three handshakes: a line fill from memory, an invalidate broadcast to the other cores, or a write-back of a dirty line.

State is held per line and is indexed by the line number. The data array, tag comparison and replacement policy sit outside the block. The tag comparison result arrives on `lcl_hit`. When `lcl_hit` is low, the line is treated as Invalid. A requester holds its request valid until the block reports it done. Each line state is one unit for the whole 64-byte line: a write to any word makes the whole line dirty.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line reads Invalid. The state encoding is Invalid=0, Shared=1, Exclusive=2, Modified=3.
- R2: A local read of an Invalid line is a miss. It can also be a miss because `lcl_hit` is low. A miss raises `fill_req`. In the cycle `fill_ack` is high, `fill_shared` is sampled. The line becomes Exclusive if `fill_shared` is low and Shared if it is high, and `lcl_done` pulses in that cycle.
- R3: A local read of a line that is Shared, Exclusive or Modified, with the tag hitting, completes in the cycle it is accepted. It causes no bus request and leaves the state unchanged.
- R4: A local write to an Exclusive line makes it Modified in the accepting cycle, with no bus request. A write to a Modified line leaves it Modified, also with no bus request.
- R5: A local write to a Shared line raises `inv_req`. When `inv_ack` arrives, the line becomes Modified.
- R6: A local write miss first fills the line. If `fill_shared` was low, the line becomes Modified. If it was high, an invalidate broadcast follows and the line then becomes Modified.
- R7: A clean (op code 2) of a Modified line raises `wb_req`. When the write-back completes, the line becomes Exclusive. A clean of any other line completes at once and changes nothing.
- R8: A snooped read (`snp_inv`=0) moves Exclusive to Shared and leaves Shared and Invalid unchanged. On a Modified line it first forces a write-back. `snp_done` stays low until `wb_ack`, and the line then becomes Shared.
- R9: A snooped invalidate (`snp_inv`=1) moves Shared or Exclusive to Invalid. On a Modified line it forces a write-back first and then makes the line Invalid.
- R10: `busy` is high while any handshake is outstanding or a snoop is presented. At most one request is raised at a time, and it and `req_idx` hold steady until acknowledged. Snoops wait while a handshake is outstanding.
- R11: When a snoop and a local request arrive in the same cycle, the snoop is served first. The local request is then judged on the state the snoop left behind.
- R12: Op code 3 completes at once and has no effect on any line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcl_valid | input | 1 | Local request present, held until `lcl_done` |
| lcl_op | input | 2 | 0 read, 1 write, 2 clean, 3 no operation |
| lcl_idx | input | IDX_W | Line index of the local request; also selects `line_state` |
| lcl_hit | input | 1 | Tag comparison matched for `lcl_idx` |
| lcl_done | output | 1 | Local request completes this cycle |
| busy | output | 1 | Local requests cannot be accepted this cycle |
| line_state | output | 2 | Stored state of line `lcl_idx` |
| snp_valid | input | 1 | Snooped event present, held until `snp_done` |
| snp_inv | input | 1 | 1 remote invalidate, 0 remote read |
| snp_idx | input | IDX_W | Line index of the snooped event |
| snp_done | output | 1 | Snooped event completes this cycle |
| fill_req | output | 1 | Line fill from memory outstanding |
| fill_ack | input | 1 | Fill complete |
| fill_shared | input | 1 | Another core holds a copy (sampled with `fill_ack`) |
| inv_req | output | 1 | Invalidate broadcast outstanding |
| inv_ack | input | 1 | All other cores have invalidated |
| wb_req | output | 1 | Write-back of a dirty line outstanding |
| wb_ack | input | 1 | Write-back complete |
| req_idx | output | IDX_W | Line index of the outstanding request |
| upd_valid | output | 1 | A line state is written this cycle |
| upd_idx | output | IDX_W | Line being written |
| upd_state | output | 2 | New state being written |

## Verification
A snooped event and a local request can fall in the same cycle. They may target the same line, for instance a remote read and a local write to an Exclusive line. The bench raises both in one cycle. It expects `snp_done` with no `lcl_done` and the line moved to Shared. It then expects the held local write to turn into an invalidate broadcast rather than a silent upgrade. A snoop that arrives during an outstanding fill is also held. The bench checks that it gets no `snp_done` until the fill has finished.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_t;

  typedef enum logic [1:0] {
    OP_RD    = 2'd0,
    OP_WR    = 2'd1,
    OP_CLEAN = 2'd2,
    OP_NOP   = 2'd3
  } lcl_op_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_FILL,
    PH_INV,
    PH_WB
  } phase_t;

  typedef enum logic [1:0] {
    WB_LOCAL,
    WB_SNP_RD,
    WB_SNP_INV
  } wb_cause_t;

  // state seen by a remote read that needs no write-back first
  function automatic line_st_t snoop_read_next(line_st_t s);
    return (s == ST_E) ? ST_S : s;
  endfunction

  // state written when a fill completes
  function automatic line_st_t fill_result(logic is_write, logic shared);
    if (shared)   return ST_S;
    if (is_write) return ST_M;
    return ST_E;
  endfunction

  // state written when a write-back completes, by its cause
  function automatic line_st_t wb_result(wb_cause_t c);
    case (c)
      WB_LOCAL:  return ST_E;
      WB_SNP_RD: return ST_S;
      default:   return ST_I;
    endcase
  endfunction

endpackage

// File: rtl/mesi_state_array.sv
module mesi_state_array
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  line_st_t         wr_state,
  input  logic [IDX_W-1:0] rd_a_idx,
  output line_st_t         rd_a_state,
  input  logic [IDX_W-1:0] rd_b_idx,
  output line_st_t         rd_b_state
);

  line_st_t ent [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent[g] <= ST_I;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        ent[g] <= wr_state;
    end
  end

  assign rd_a_state = ent[rd_a_idx];
  assign rd_b_state = ent[rd_b_idx];

endmodule

// File: rtl/mesi_track.sv
module mesi_track
  import mesi_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_t           nxt_phase,
  input  logic             ld,
  input  logic [IDX_W-1:0] nxt_idx,
  input  logic             nxt_wr,
  input  wb_cause_t        nxt_cause,
  output phase_t           phase,
  output logic [IDX_W-1:0] cur_idx,
  output logic             cur_wr,
  output wb_cause_t        cur_cause
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cur_idx   <= '0;
      cur_wr    <= 1'b0;
      cur_cause <= WB_LOCAL;
    end else begin
      phase <= nxt_phase;
      if (ld) begin
        cur_idx   <= nxt_idx;
        cur_wr    <= nxt_wr;
        cur_cause <= nxt_cause;
      end
    end
  end

endmodule

// File: rtl/mesi_decide.sv
module mesi_decide
  import mesi_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  phase_t           phase,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic             cur_wr,
  input  wb_cause_t        cur_cause,
  input  logic             snp_valid,
  input  logic             snp_inv,
  input  logic [IDX_W-1:0] snp_idx,
  input  line_st_t         snp_st,
  input  logic             lcl_valid,
  input  lcl_op_t          lcl_op,
  input  logic [IDX_W-1:0] lcl_idx,
  input  logic             lcl_hit,
  input  line_st_t         lcl_st,
  input  logic             fill_ack,
  input  logic             fill_shared,
  input  logic             inv_ack,
  input  logic             wb_ack,
  output phase_t           nxt_phase,
  output logic             ld,
  output logic [IDX_W-1:0] nxt_idx,
  output logic             nxt_wr,
  output wb_cause_t        nxt_cause,
  output logic             upd_valid,
  output logic [IDX_W-1:0] upd_idx,
  output line_st_t         upd_state,
  output logic             lcl_done,
  output logic             snp_done,
  output logic             snp_take,
  output logic             lcl_take
);

  line_st_t eff_st;

  assign eff_st   = lcl_hit ? lcl_st : ST_I;
  assign snp_take = (phase == PH_IDLE) && snp_valid;
  assign lcl_take = (phase == PH_IDLE) && !snp_valid && lcl_valid;

  always_comb begin
    nxt_phase = phase;
    ld        = 1'b0;
    nxt_idx   = cur_idx;
    nxt_wr    = cur_wr;
    nxt_cause = cur_cause;
    upd_valid = 1'b0;
    upd_idx   = cur_idx;
    upd_state = ST_I;
    lcl_done  = 1'b0;
    snp_done  = 1'b0;

    case (phase)
      PH_IDLE: begin
        if (snp_take) begin
          if (snp_st == ST_M) begin
            nxt_phase = PH_WB;
            ld        = 1'b1;
            nxt_idx   = snp_idx;
            nxt_cause = snp_inv ? WB_SNP_INV : WB_SNP_RD;
          end else begin
            snp_done  = 1'b1;
            upd_valid = 1'b1;
            upd_idx   = snp_idx;
            upd_state = snp_inv ? ST_I : snoop_read_next(snp_st);
          end
        end else if (lcl_take) begin
          ld        = 1'b1;
          nxt_idx   = lcl_idx;
          nxt_wr    = (lcl_op == OP_WR);
          nxt_cause = WB_LOCAL;
          case (lcl_op)
            OP_RD: begin
              if (eff_st == ST_I) nxt_phase = PH_FILL;
              else                lcl_done  = 1'b1;
            end
            OP_WR: begin
              case (eff_st)
                ST_I: nxt_phase = PH_FILL;
                ST_S: nxt_phase = PH_INV;
                ST_E: begin
                  upd_valid = 1'b1;
                  upd_idx   = lcl_idx;
                  upd_state = ST_M;
                  lcl_done  = 1'b1;
                end
                default: lcl_done = 1'b1;
              endcase
            end
            OP_CLEAN: begin
              if (eff_st == ST_M) nxt_phase = PH_WB;
              else                lcl_done  = 1'b1;
            end
            default: lcl_done = 1'b1;
          endcase
        end
      end

      PH_FILL: begin
        if (fill_ack) begin
          upd_valid = 1'b1;
          upd_state = fill_result(cur_wr, fill_shared);
          if (cur_wr && fill_shared) begin
            nxt_phase = PH_INV;
          end else begin
            nxt_phase = PH_IDLE;
            lcl_done  = 1'b1;
          end
        end
      end

      PH_INV: begin
        if (inv_ack) begin
          upd_valid = 1'b1;
          upd_state = ST_M;
          nxt_phase = PH_IDLE;
          lcl_done  = 1'b1;
        end
      end

      default: begin
        if (wb_ack) begin
          upd_valid = 1'b1;
          upd_state = wb_result(cur_cause);
          nxt_phase = PH_IDLE;
          if (cur_cause == WB_LOCAL) lcl_done = 1'b1;
          else                       snp_done = 1'b1;
        end
      end
    endcase
  end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter  int NUM_LINES = 16,
  localparam int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lcl_valid,
  input  logic [1:0]       lcl_op,
  input  logic [IDX_W-1:0] lcl_idx,
  input  logic             lcl_hit,
  output logic             lcl_done,
  output logic             busy,
  output logic [1:0]       line_state,
  input  logic             snp_valid,
  input  logic             snp_inv,
  input  logic [IDX_W-1:0] snp_idx,
  output logic             snp_done,
  output logic             fill_req,
  input  logic             fill_ack,
  input  logic             fill_shared,
  output logic             inv_req,
  input  logic             inv_ack,
  output logic             wb_req,
  input  logic             wb_ack,
  output logic [IDX_W-1:0] req_idx,
  output logic             upd_valid,
  output logic [IDX_W-1:0] upd_idx,
  output logic [1:0]       upd_state
);

  phase_t           phase, nxt_phase;
  logic             ld, nxt_wr, cur_wr;
  logic [IDX_W-1:0] nxt_idx, cur_idx;
  wb_cause_t        nxt_cause, cur_cause;
  line_st_t         snp_st, lcl_st, upd_st_t;
  logic             snp_take, lcl_take;

  mesi_state_array #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_arr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (upd_valid),
    .wr_idx     (upd_idx),
    .wr_state   (upd_st_t),
    .rd_a_idx   (snp_idx),
    .rd_a_state (snp_st),
    .rd_b_idx   (lcl_idx),
    .rd_b_state (lcl_st)
  );

  mesi_track #(.IDX_W(IDX_W)) u_trk (
    .clk       (clk),
    .rst_n     (rst_n),
    .nxt_phase (nxt_phase),
    .ld        (ld),
    .nxt_idx   (nxt_idx),
    .nxt_wr    (nxt_wr),
    .nxt_cause (nxt_cause),
    .phase     (phase),
    .cur_idx   (cur_idx),
    .cur_wr    (cur_wr),
    .cur_cause (cur_cause)
  );

  mesi_decide #(.IDX_W(IDX_W)) u_dec (
    .phase       (phase),
    .cur_idx     (cur_idx),
    .cur_wr      (cur_wr),
    .cur_cause   (cur_cause),
    .snp_valid   (snp_valid),
    .snp_inv     (snp_inv),
    .snp_idx     (snp_idx),
    .snp_st      (snp_st),
    .lcl_valid   (lcl_valid),
    .lcl_op      (lcl_op_t'(lcl_op)),
    .lcl_idx     (lcl_idx),
    .lcl_hit     (lcl_hit),
    .lcl_st      (lcl_st),
    .fill_ack    (fill_ack),
    .fill_shared (fill_shared),
    .inv_ack     (inv_ack),
    .wb_ack      (wb_ack),
    .nxt_phase   (nxt_phase),
    .ld          (ld),
    .nxt_idx     (nxt_idx),
    .nxt_wr      (nxt_wr),
    .nxt_cause   (nxt_cause),
    .upd_valid   (upd_valid),
    .upd_idx     (upd_idx),
    .upd_state   (upd_st_t),
    .lcl_done    (lcl_done),
    .snp_done    (snp_done),
    .snp_take    (snp_take),
    .lcl_take    (lcl_take)
  );

  assign upd_state  = upd_st_t;
  assign line_state = lcl_st;
  assign fill_req   = (phase == PH_FILL);
  assign inv_req    = (phase == PH_INV);
  assign wb_req     = (phase == PH_WB);
  assign req_idx    = cur_idx;
  assign busy       = (phase != PH_IDLE) || snp_valid;

endmodule

// File: rtl/mesi_chk.sv
module mesi_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fill_req,
  input logic             fill_ack,
  input logic             inv_req,
  input logic             inv_ack,
  input logic             wb_req,
  input logic             busy,
  input logic [IDX_W-1:0] req_idx,
  input logic             lcl_done,
  input logic [1:0]       lcl_op,
  input logic             lcl_hit,
  input logic [1:0]       line_state,
  input logic             upd_valid,
  input logic [1:0]       upd_state,
  input logic             snp_take,
  input logic             lcl_take
);

  // R10
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fill_req, inv_req, wb_req}));

  // R10
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req || inv_req || wb_req) |-> busy);

  // R10
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !fill_ack) |=> (fill_req && $stable(req_idx)));

  // R11
  snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_take |-> !lcl_done);

  // R4
  silent_upgrade_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lcl_take && lcl_op == 2'd1 && lcl_hit && line_state == 2'd2)
      |-> (lcl_done && upd_valid && upd_state == 2'd3));

  // R4
  silent_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lcl_take && lcl_op == 2'd1 && lcl_hit && line_state == 2'd2)
      |=> !(fill_req || inv_req || wb_req));

  // R5
  inv_promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && inv_ack) |-> (upd_valid && upd_state == 2'd3));

endmodule

bind mesi_line_ctrl mesi_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fill_req   (fill_req),
  .fill_ack   (fill_ack),
  .inv_req    (inv_req),
  .inv_ack    (inv_ack),
  .wb_req     (wb_req),
  .busy       (busy),
  .req_idx    (req_idx),
  .lcl_done   (lcl_done),
  .lcl_op     (lcl_op),
  .lcl_hit    (lcl_hit),
  .line_state (line_state),
  .upd_valid  (upd_valid),
  .upd_state  (upd_state),
  .snp_take   (snp_take),
  .lcl_take   (lcl_take)
);

// File: tb/sim_mesi_line_ctrl.sv
module sim_mesi_line_ctrl;

  localparam int NL = 16;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lcl_valid = 1'b0;
  logic [1:0]    lcl_op = 2'd0;
  logic [IW-1:0] lcl_idx = '0;
  logic          lcl_hit = 1'b1;
  logic          lcl_done, busy;
  logic [1:0]    line_state;
  logic          snp_valid = 1'b0;
  logic          snp_inv = 1'b0;
  logic [IW-1:0] snp_idx = '0;
  logic          snp_done;
  logic          fill_req, inv_req, wb_req;
  logic          fill_ack = 1'b0, fill_shared = 1'b0, inv_ack = 1'b0, wb_ack = 1'b0;
  logic [IW-1:0] req_idx, upd_idx;
  logic          upd_valid;
  logic [1:0]    upd_state;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mesi_line_ctrl #(.NUM_LINES(NL)) u0 (
    .clk(clk), .rst_n(rst_n),
    .lcl_valid(lcl_valid), .lcl_op(lcl_op), .lcl_idx(lcl_idx), .lcl_hit(lcl_hit),
    .lcl_done(lcl_done), .busy(busy), .line_state(line_state),
    .snp_valid(snp_valid), .snp_inv(snp_inv), .snp_idx(snp_idx), .snp_done(snp_done),
    .fill_req(fill_req), .fill_ack(fill_ack), .fill_shared(fill_shared),
    .inv_req(inv_req), .inv_ack(inv_ack),
    .wb_req(wb_req), .wb_ack(wb_ack),
    .req_idx(req_idx),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_state(upd_state)
  );

  // snp, op (snoop: 0 read 1 inv), idx, hit, shared, expected state, fill, inv, wb
  typedef struct packed {
    logic       snp;
    logic [1:0] op;
    logic [3:0] idx;
    logic       hit;
    logic       shr;
    logic [1:0] est;
    logic       ef;
    logic       ei;
    logic       ew;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 4'd1,  1'b1, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0},  // R2 read miss, alone -> E
    '{1'b0, 2'd1, 4'd1,  1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0},  // R4 E write -> M silent
    '{1'b0, 2'd1, 4'd1,  1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0},  // R4 M write stays M
    '{1'b0, 2'd2, 4'd1,  1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1},  // R7 clean M -> E
    '{1'b1, 2'd0, 4'd1,  1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0},  // R8 snoop read E -> S
    '{1'b0, 2'd1, 4'd1,  1'b1, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0},  // R5 S write -> inv -> M
    '{1'b1, 2'd0, 4'd1,  1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1},  // R8 snoop read M -> wb -> S
    '{1'b1, 2'd1, 4'd1,  1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},  // R9 snoop inv S -> I
    '{1'b0, 2'd0, 4'd2,  1'b1, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0},  // R2 read miss, shared -> S
    '{1'b0, 2'd0, 4'd2,  1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0},  // R3 read hit S
    '{1'b1, 2'd1, 4'd2,  1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},  // R9 snoop inv S -> I
    '{1'b0, 2'd1, 4'd3,  1'b1, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0},  // R6 write miss alone -> M
    '{1'b1, 2'd1, 4'd3,  1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1},  // R9 snoop inv M -> wb -> I
    '{1'b0, 2'd1, 4'd4,  1'b1, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0},  // R6 write miss shared -> fill, inv, M
    '{1'b0, 2'd0, 4'd4,  1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0},  // R2 tag miss on M line refills -> S
    '{1'b0, 2'd2, 4'd4,  1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0},  // R7 clean of S no effect
    '{1'b0, 2'd3, 4'd4,  1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0},  // R12 op 3 no effect
    '{1'b1, 2'd0, 4'd5,  1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},  // R8 snoop read I stays I
    '{1'b0, 2'd0, 4'd15, 1'b1, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0},  // R2 last index -> E
    '{1'b0, 2'd0, 4'd15, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0},  // R3 read hit E
    '{1'b0, 2'd1, 4'd15, 1'b0, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0}   // R6 write with tag miss -> fill -> M
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic read_state(input logic [IW-1:0] idx, output logic [1:0] st);
    lcl_idx = idx;
    #1;
    st = line_state;
  endtask

  task automatic run_op(input logic is_snp, input logic [1:0] op, input logic [IW-1:0] idx,
                        input logic hit, input logic shr,
                        output logic f, output logic i, output logic w, output logic ok);
    f = 1'b0; i = 1'b0; w = 1'b0; ok = 1'b0;
    @(negedge clk);
    if (is_snp) begin
      snp_valid = 1'b1; snp_inv = op[0]; snp_idx = idx;
    end else begin
      lcl_valid = 1'b1; lcl_op = op; lcl_idx = idx; lcl_hit = hit;
    end
    for (int n = 0; n < 16 && !ok; n++) begin
      #1;
      if (fill_req) begin f = 1'b1; fill_ack = 1'b1; fill_shared = shr; end
      if (inv_req)  begin i = 1'b1; inv_ack = 1'b1; end
      if (wb_req)   begin w = 1'b1; wb_ack = 1'b1; end
      #1;
      ok = is_snp ? snp_done : lcl_done;
      @(negedge clk);
      fill_ack = 1'b0; inv_ack = 1'b0; wb_ack = 1'b0; fill_shared = 1'b0;
    end
    snp_valid = 1'b0; lcl_valid = 1'b0; lcl_hit = 1'b1;
  endtask

  initial begin
    #(20000 * 10);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic f, i, w, ok;
    logic [1:0] st;
    logic seen_bad;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: every line Invalid after reset, nothing outstanding
    seen_bad = 1'b0;
    for (int k = 0; k < NL; k++) begin
      read_state(IW'(k), st);
      if (st != 2'd0) seen_bad = 1'b1;
    end
    check(!seen_bad, "R1 lines invalid", int'(seen_bad), 0);
    check(!busy && !fill_req && !inv_req && !wb_req, "R1 idle after reset",
          int'({busy, fill_req, inv_req, wb_req}), 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      run_op(VEC[v].snp, VEC[v].op, VEC[v].idx, VEC[v].hit, VEC[v].shr, f, i, w, ok);
      check(ok, $sformatf("vec %0d completes", v), int'(ok), 1);
      read_state(VEC[v].idx, st);
      check(st == VEC[v].est, $sformatf("vec %0d state", v), int'(st), int'(VEC[v].est));
      check(f == VEC[v].ef, $sformatf("vec %0d fill", v), int'(f), int'(VEC[v].ef));
      check(i == VEC[v].ei, $sformatf("vec %0d inv", v), int'(i), int'(VEC[v].ei));
      check(w == VEC[v].ew, $sformatf("vec %0d wb", v), int'(w), int'(VEC[v].ew));
    end

    // R11: snoop read and local write to the same Exclusive line in one cycle
    run_op(1'b0, 2'd0, 4'd6, 1'b1, 1'b0, f, i, w, ok);
    @(negedge clk);
    snp_valid = 1'b1; snp_inv = 1'b0; snp_idx = 4'd6;
    lcl_valid = 1'b1; lcl_op = 2'd1; lcl_idx = 4'd6; lcl_hit = 1'b1;
    #1;
    check(snp_done && !lcl_done && busy, "R11 snoop served first",
          int'({snp_done, lcl_done, busy}), 5);
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
    check(line_state == 2'd1, "R11 line shared after snoop", int'(line_state), 1);
    check(!lcl_done, "R11 write not silent on shared", int'(lcl_done), 0);
    @(negedge clk);
    check(inv_req && req_idx == 4'd6, "R11 R5 invalidate raised", int'(inv_req), 1);
    inv_ack = 1'b1;
    #1;
    check(lcl_done, "R5 done on inv ack", int'(lcl_done), 1);
    @(negedge clk);
    inv_ack = 1'b0; lcl_valid = 1'b0;
    read_state(4'd6, st);
    check(st == 2'd3, "R5 promoted to modified", int'(st), 3);

    // R10: snoop waits while a fill is outstanding
    @(negedge clk);
    lcl_valid = 1'b1; lcl_op = 2'd0; lcl_idx = 4'd8; lcl_hit = 1'b1;
    @(negedge clk);
    lcl_idx = 4'd9;
    snp_valid = 1'b1; snp_inv = 1'b1; snp_idx = 4'd6;
    seen_bad = 1'b0;
    for (int n = 0; n < 3; n++) begin
      #1;
      if (!fill_req || req_idx != 4'd8 || !busy || snp_done || lcl_done) seen_bad = 1'b1;
      @(negedge clk);
    end
    check(!seen_bad, "R10 fill held, snoop waits", int'(seen_bad), 0);
    snp_valid = 1'b0;
    lcl_idx = 4'd8;
    fill_ack = 1'b1; fill_shared = 1'b0;
    #1;
    check(lcl_done && !snp_done, "R2 done on fill ack", int'({lcl_done, snp_done}), 2);
    @(negedge clk);
    fill_ack = 1'b0; lcl_valid = 1'b0;
    read_state(4'd8, st);
    check(st == 2'd2, "R2 filled exclusive", int'(st), 2);
    read_state(4'd6, st);
    check(st == 2'd3, "R10 withdrawn snoop left line", int'(st), 3);

    // R8: snoop read of a modified line holds snp_done until write-back
    @(negedge clk);
    snp_valid = 1'b1; snp_inv = 1'b0; snp_idx = 4'd6;
    #1;
    check(!snp_done, "R8 no done before write-back", int'(snp_done), 0);
    @(negedge clk);
    @(negedge clk);
    #1;
    check(wb_req && !snp_done && req_idx == 4'd6, "R8 write-back held",
          int'({wb_req, snp_done}), 2);
    wb_ack = 1'b1;
    #1;
    check(snp_done, "R8 done with write-back ack", int'(snp_done), 1);
    @(negedge clk);
    wb_ack = 1'b0; snp_valid = 1'b0;
    read_state(4'd6, st);
    check(st == 2'd1, "R8 shared after write-back", int'(st), 1);

    // R12: op 3 on a modified line changes nothing and raises no request
    run_op(1'b0, 2'd1, 4'd10, 1'b1, 1'b0, f, i, w, ok);
    run_op(1'b0, 2'd3, 4'd10, 1'b1, 1'b0, f, i, w, ok);
    read_state(4'd10, st);
    check(ok && st == 2'd3 && !f && !i && !w, "R12 no effect on modified", int'(st), 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule